// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns one parallel byte into an asynchronous serial character on a single output line. A character starts with a low start bit. Then come 5 to 8 data bits, least significant bit first, and an optional parity bit. It ends with one, one and a half, or two high stop bits. A built-in divisor divides the serial clock to make a tick at sixteen times the bit rate. Every bit lasts sixteen ticks.

A holding register or FIFO offers bytes through a valid/ready handshake. The format fields and the byte are captured when the handshake completes. Characters can follow one another with no idle time between them. A break control pulls the line low at any time, without disturbing the character timing. The block reports a busy flag and a shift-register-empty flag.

Top module: `uart_char_tx`

## Requirements
- R1: After reset the line is high, `busy` is 0, `shift_empty` is 1, and `tx_ready` is 1 whenever `divisor` is nonzero.
- R2: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. From that edge, every bit of the character lasts 16 × `divisor` clock cycles.
- R3: While `divisor` is 0 no tick is produced and `tx_ready` stays 0. No character starts, the line stays high and `busy` stays 0.
- R4: The character is one low start bit followed by the data bits, least significant bit first. The number of data bits comes from `data_len`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of `tx_data` are ignored.
- R5: When `parity_en` is 1, a parity bit follows the last data bit. With `even_par` = 1 the data bits plus the parity bit hold an even number of ones. With `even_par` = 0 they hold an odd number.
- R6: The stop period is high. With `two_stop` = 0 it lasts 16 ticks. With `two_stop` = 1 it lasts 24 ticks when `data_len` is 00, and 32 ticks otherwise.
- R7: While `brk` is 1 the line is 0, whatever the state of the character. Character timing goes on unchanged.
- R8: `tx_ready` is high in idle and in the last cycle of the final stop period. A byte offered then starts its start bit directly after the stop period, with no idle cycles.
- R9: `busy` is 1 from the accepting edge to the end of the stop period. `shift_empty` is its inverse, and the line is high when `busy` is 0 and `brk` is 0.
- R10: The byte and the format fields are captured when the byte is accepted. Changing the inputs during a character does not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Bit-rate divisor; 0 stops the tick |
| data_len | input | 2 | Data length code: 00 = 5 bits up to 11 = 8 bits |
| two_stop | input | 1 | Long stop period select |
| parity_en | input | 1 | Parity bit enable |
| even_par | input | 1 | 1 = even parity, 0 = odd parity |
| brk | input | 1 | Forces the line low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte can be accepted this cycle |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Character in progress |
| shift_empty | output | 1 | No character being shifted |

## Verification
A table of characters covers all four data lengths, all three stop lengths, odd parity, even parity and no parity, and divisors of 1, 2 and 3. Sampling each bit at its middle catches errors in bit order, masking and parity polarity. Checking `busy` one cycle before and at the computed end catches a stop period of the wrong length, or a bit time that is not scaled by the divisor. Directed cases cover a zero divisor, a back-to-back pair of characters, break while idle and during a character, and inputs changed in the middle of a character.

// File: rtl/uart_char_tx.sv
module uart_char_tx #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       data_len,
  input  logic             two_stop,
  input  logic             parity_en,
  input  logic             even_par,
  input  logic             brk,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  output logic             busy,
  output logic             shift_empty
);
  localparam int SUB_W = $clog2(2 * OVS);
  localparam logic [SUB_W-1:0] LAST_ONE  = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] LAST_HALF = SUB_W'(OVS + OVS / 2 - 1);
  localparam logic [SUB_W-1:0] LAST_TWO  = SUB_W'(2 * OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic [SUB_W-1:0] sub, last_sub, stop_last;
  logic [2:0]       idx;
  logic [7:0]       shreg, masked;
  logic             par_q, pen_q, stop_q;
  logic [1:0]       len_q;
  logic             tick, bit_end, accept, div_on;

  assign div_on    = divisor != '0;
  assign tick      = div_on && (cnt >= divisor - 1'b1);
  assign stop_last = !stop_q ? LAST_ONE : (len_q == 2'b00 ? LAST_HALF : LAST_TWO);
  assign last_sub  = (st == S_STOP) ? stop_last : LAST_ONE;
  assign bit_end   = tick && (sub == last_sub);
  assign tx_ready  = div_on && (st == S_IDLE || (st == S_STOP && bit_end));
  assign accept    = tx_valid && tx_ready;
  assign masked    = tx_data & (8'hFF >> (2'd3 - data_len));

  assign busy        = st != S_IDLE;
  assign shift_empty = st == S_IDLE;

  always_comb begin
    if (brk) txd = 1'b0;
    else begin
      case (st)
        S_START: txd = 1'b0;
        S_DATA:  txd = shreg[0];
        S_PAR:   txd = par_q;
        default: txd = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (accept || !div_on || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sub <= '0; idx <= '0; shreg <= '0;
      par_q <= 1'b0; pen_q <= 1'b0; stop_q <= 1'b0; len_q <= 2'b00;
    end else if (accept) begin
      st     <= S_START;
      sub    <= '0;
      idx    <= '0;
      shreg  <= masked;
      par_q  <= (^masked) ^ ~even_par;
      pen_q  <= parity_en;
      stop_q <= two_stop;
      len_q  <= data_len;
    end else if (tick && st != S_IDLE) begin
      if (bit_end) begin
        sub <= '0;
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            shreg <= shreg >> 1;
            if (idx == {1'b1, len_q}) st <= pen_q ? S_PAR : S_STOP;
            else idx <= idx + 1'b1;
          end
          S_PAR:   st <= S_STOP;
          default: st <= S_IDLE;
        endcase
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  a_r3_zero_div_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_on && !busy) |=> !busy);
  a_r8_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy);
  a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !brk) |-> !txd);
  a_r9_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> txd);
  a_r2_ready_needs_tick_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_ready) |=> $past(tick));
endmodule

// File: tb/uart_char_tx_test.sv
module uart_char_tx_test;
  localparam int CLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [1:0] data_len = 2'b11;
  logic two_stop = 1'b0, parity_en = 1'b0, even_par = 1'b0, brk = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0;
  logic tx_ready, txd, busy, shift_empty;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK/2) clk = ~clk;

  uart_char_tx uut (.clk(clk), .rst_n(rst_n), .divisor(divisor), .data_len(data_len),
    .two_stop(two_stop), .parity_en(parity_en), .even_par(even_par), .brk(brk),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .busy(busy), .shift_empty(shift_empty));

  // {divisor[15:0], data[7:0], len[1:0], two_stop, parity_en, even_par}
  localparam logic [28:0] VEC [7] = '{
    {16'd1, 8'hA5, 2'b11, 1'b0, 1'b0, 1'b0},
    {16'd1, 8'h3C, 2'b11, 1'b1, 1'b1, 1'b1},
    {16'd1, 8'h3D, 2'b11, 1'b0, 1'b1, 1'b0},
    {16'd1, 8'h15, 2'b00, 1'b1, 1'b0, 1'b0},
    {16'd2, 8'h2D, 2'b01, 1'b1, 1'b1, 1'b0},
    {16'd3, 8'h55, 2'b10, 1'b0, 1'b1, 1'b1},
    {16'd1, 8'hE0, 2'b00, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic offer(input logic [7:0] d, input logic [1:0] l, input logic s,
                       input logic p, input logic e, input logic [15:0] dv);
    @(negedge clk);
    tx_data = d; data_len = l; two_stop = s; parity_en = p; even_par = e; divisor = dv;
    tx_valid = 1'b1;
    #1 chk(tx_ready === 1'b1, "R8 ready in idle", int'(tx_ready), 1);
    @(posedge clk);
  endtask

  // Called right after the accepting edge.
  task automatic frame(input logic [7:0] d, input logic [1:0] l, input logic s,
                       input logic p, input logic e, input int dv, input bit chain,
                       input logic [7:0] nd, input int bon, input int boff, input bit scramble);
    int n, nb, t, bt, last;
    logic [7:0] md;
    logic [11:0] exp_bits;
    n = 5 + int'(l);
    md = d & (8'hFF >> (3 - int'(l)));
    exp_bits = '1;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < n; i++) exp_bits[1 + i] = md[i];
    if (p) exp_bits[n + 1] = (^md) ^ ~e;
    nb = 1 + n + int'(p) + 1;
    bt = 16 * dv;
    t = dv * (16 * (1 + n + int'(p)) + (s ? (l == 2'b00 ? 24 : 32) : 16));
    last = chain ? t - 1 : t;
    for (int c = 0; c <= last; c++) begin
      if (c > 0) @(posedge clk);
      @(negedge clk);
      if (c == 0) tx_valid = 1'b0;
      if (c == 1 && scramble) begin
        tx_data = ~d; data_len = ~l; two_stop = ~s; parity_en = ~p; even_par = ~e;
      end
      if (c == bon) brk = 1'b1;
      if (c == boff) brk = 1'b0;
      #1;
      if (c == 0) chk(busy === 1'b1 && shift_empty === 1'b0, "R9 busy after accept", int'(busy), 1);
      if (brk) begin
        if (c == bon) chk(txd === 1'b0, "R7 break forces low", int'(txd), 0);
      end else if (c % bt == bt / 2 && c / bt < nb) begin
        chk(txd === exp_bits[c / bt], scramble ? "R10 captured format" :
            (c / bt == n + 1 && p) ? "R5 parity bit" : "R4 frame bit", int'(txd),
            int'(exp_bits[c / bt]));
      end
      if (c == t - 1) chk(busy === 1'b1, "R6 stop length (busy before end)", int'(busy), 1);
      if (!chain && c == t)
        chk(busy === 1'b0 && shift_empty === 1'b1, "R6 stop length (idle at end)", int'(busy), 0);
      if (chain && c == t - 2) begin tx_data = nd; tx_valid = 1'b1; end
      if (chain && c == t - 1) chk(tx_ready === 1'b1, "R8 ready at final stop", int'(tx_ready), 1);
    end
    if (chain) @(posedge clk);
  endtask

  initial begin
    #(CLK * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(txd === 1'b1, "R1 idle line", int'(txd), 1);
    chk(busy === 1'b0 && shift_empty === 1'b1, "R1 idle flags", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(tx_ready === 1'b1, "R1 ready after reset", int'(tx_ready), 1);

    for (int v = 0; v < 7; v++) begin
      offer(VEC[v][12:5], VEC[v][4:3], VEC[v][2], VEC[v][1], VEC[v][0], VEC[v][28:13]);
      frame(VEC[v][12:5], VEC[v][4:3], VEC[v][2], VEC[v][1], VEC[v][0], int'(VEC[v][28:13]),
            1'b0, 8'h00, -1, -1, 1'b0);
    end

    // R3: zero divisor
    @(negedge clk);
    divisor = 16'd0; tx_data = 8'h00; tx_valid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (i % 10 == 0) begin
        chk(tx_ready === 1'b0, "R3 no ready at zero divisor", int'(tx_ready), 0);
        chk(busy === 1'b0 && txd === 1'b1, "R3 no activity", int'(busy), 0);
      end
    end
    tx_valid = 1'b0; divisor = 16'd1;
    repeat (5) @(negedge clk);
    #1 chk(busy === 1'b0, "R3 nothing queued", int'(busy), 0);

    // R8: back-to-back characters
    offer(8'h96, 2'b11, 1'b0, 1'b1, 1'b1, 16'd1);
    frame(8'h96, 2'b11, 1'b0, 1'b1, 1'b1, 1, 1'b1, 8'h0F, -1, -1, 1'b0);
    frame(8'h0F, 2'b11, 1'b0, 1'b1, 1'b1, 1, 1'b0, 8'h00, -1, -1, 1'b0);

    // R7: break while idle
    @(negedge clk);
    brk = 1'b1; #1;
    chk(txd === 1'b0 && busy === 1'b0, "R7 break in idle", int'(txd), 0);
    @(negedge clk) brk = 1'b0; #1;
    chk(txd === 1'b1, "R7 break released", int'(txd), 1);

    // R7: break mid-character on all-ones data, timing unchanged
    offer(8'hFF, 2'b11, 1'b0, 1'b0, 1'b0, 16'd1);
    frame(8'hFF, 2'b11, 1'b0, 1'b0, 1'b0, 1, 1'b0, 8'h00, 30, 70, 1'b0);

    // R10: inputs change during a character
    offer(8'h6B, 2'b10, 1'b1, 1'b1, 1'b0, 16'd2);
    frame(8'h6B, 2'b10, 1'b1, 1'b1, 1'b0, 2, 1'b0, 8'h00, -1, -1, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule